// File: doc/BRIEF.md
# Configurable Two-Plane Logic Array

This block is a small sum-of-products logic array with three inputs, four product terms and two outputs. Both planes are programmable. In the AND plane, each true and each complemented input literal can be tied to each product term. In the OR plane, each product term can be tied to each output. Because the OR plane is programmable, one product term can feed both outputs.

A mode bit replaces the OR plane with a fixed assignment: terms 0 and 1 drive output 0, and terms 2 and 3 drive output 1. The outputs are combinational in the inputs.

The configuration arrives one bit per clock on a serial chain while the shift enable is high. It is held in a shadow register and is only copied into the working register when a commit pulse arrives. A user can therefore rewrite the whole pattern while the array keeps evaluating the previous one.

Top module: `lpa_array`

## Requirements
- R1: Synchronous reset clears both the shadow and the working configuration. After reset `f_out` is 0 for every value of `x_in`.
- R2: While `cfg_shift` is high, each clock moves every shadow bit one place up and loads `cfg_din` into bit 0. The first bit sent therefore ends at bit 32 after 33 shifts (MSB-first).
- R3: Configuration word layout:
  - Bit 0 is the fixed-OR mode.
  - Bit 1+4*o+t links term t to output o.
  - Bit 9+6*t+2*i selects true input i for term t.
  - Bit 10+6*t+2*i selects complemented input i for term t.
  - Input i is `x_in[i]`.
- R4: The working configuration changes only on a clock where `cfg_commit` is high. Shifting without a commit leaves `f_out` unchanged.
- R5: A product term is the AND of its selected literals. A term with no selected literal is 1.
- R6: A term that selects both the true and the complemented literal of the same input is always 0.
- R7: In free mode, an output is the OR of its linked terms. An output with no link is 0, and one term may feed both outputs.
- R8: In fixed-OR mode, terms 0 and 1 drive `f_out[0]` and terms 2 and 3 drive `f_out[1]`. All OR-plane bits are ignored.
- R9: One pattern realises both of these at once, with the terms x1x2 and x1'x2'x3 shared (x1 = `x_in[0]`, x2 = `x_in[1]`, x3 = `x_in[2]`):
  - f1 = x1x2 + x1x3' + x1'x2'x3
  - f2 = x1x2 + x1'x2'x3 + x1x3
- R10: When shift and commit are both high in one clock, the working configuration takes the shadow value from before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift enable for the serial configuration chain |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| cfg_commit | input | 1 | Copies the shadow pattern into the working pattern |
| x_in | input | 3 | Array inputs |
| f_out | output | 2 | Combinational array outputs |

## Verification
The bench builds the array with its default sizes: 3 inputs, 4 terms and 2 outputs. At these sizes a 33-bit word covers every input combination and every corner of the configuration. This lets the bench sweep all eight input values for each pattern it loads. The patterns cover empty terms, contradictory terms, unlinked outputs, shared terms and the fixed-OR mode with stray OR bits set. The bench also covers a commit in the same cycle as a shift and a partly shifted pattern that is never committed.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
    localparam int N_IN          = 3;
    localparam int N_TERM        = 4;
    localparam int N_OUT         = 2;
    localparam int N_LIT         = 2 * N_IN;
    localparam int OR_BITS       = N_TERM * N_OUT;
    localparam int AND_BITS      = N_TERM * N_LIT;
    localparam int CFG_W         = 1 + OR_BITS + AND_BITS;
    localparam int TERMS_PER_OUT = N_TERM / N_OUT;

    typedef logic [N_TERM-1:0][N_LIT-1:0] and_map_t;
    typedef logic [N_OUT-1:0][N_TERM-1:0] or_map_t;

    // Packed from MSB: AND plane, then OR plane, then the mode bit at bit 0.
    typedef struct packed {
        and_map_t and_map;
        or_map_t  or_map;
        logic     pal_mode;
    } cfg_t;

    // Literal 2*i is input i, literal 2*i+1 is its complement.
    function automatic logic [N_LIT-1:0] expand_literals(logic [N_IN-1:0] x);
        logic [N_LIT-1:0] lits;
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = x[i];
            lits[2*i+1] = ~x[i];
        end
        return lits;
    endfunction

    // Terms an output owns when the OR plane is fixed.
    function automatic logic [N_TERM-1:0] owned_terms(int o);
        logic [N_TERM-1:0] m;
        for (int t = 0; t < N_TERM; t++)
            m[t] = ((t / TERMS_PER_OUT) == o);
        return m;
    endfunction
endpackage

// File: rtl/lpa_cfg_chain.sv
module lpa_cfg_chain
    import lpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic ser_in,
    input  logic commit,
    output cfg_t active_cfg
);
    logic [CFG_W-1:0] shadow_q;
    logic [CFG_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (commit)
                active_q <= shadow_q;
            if (shift_en)
                shadow_q <= {shadow_q[CFG_W-2:0], ser_in};
        end
    end

    assign active_cfg = cfg_t'(active_q);

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (active_q == '0 && shadow_q == '0));

    // R4
    hold_without_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q));

    // R10
    commit_takes_old_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == $past(shadow_q)));

    // R2
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (shadow_q[0] == $past(ser_in) &&
                      shadow_q[CFG_W-1:1] == $past(shadow_q[CFG_W-2:0])));
endmodule

// File: rtl/lpa_and_plane.sv
module lpa_and_plane
    import lpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  and_map_t          and_map,
    input  logic [N_IN-1:0]   x,
    output logic [N_TERM-1:0] term
);
    logic [N_LIT-1:0] lits;

    assign lits = expand_literals(x);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // An unselected literal is forced to 1 so it cannot pull the term low.
        assign term[t] = &(lits | ~and_map[t]);

        for (genvar i = 0; i < N_IN; i++) begin : g_conflict
            // R6
            contradiction_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (and_map[t][2*i] && and_map[t][2*i+1]) |-> !term[t]);
        end

        // R5
        empty_term_one_chk: assert property (@(posedge clk) disable iff (rst)
            (and_map[t] == '0) |-> term[t]);
    end
endmodule

// File: rtl/lpa_or_plane.sv
module lpa_or_plane
    import lpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  or_map_t           or_map,
    input  logic              pal_mode,
    input  logic [N_TERM-1:0] term,
    output logic [N_OUT-1:0]  f
);
    or_map_t link;

    always_comb begin
        for (int o = 0; o < N_OUT; o++)
            link[o] = pal_mode ? owned_terms(o) : or_map[o];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign f[o] = |(term & link[o]);

        // R8
        fixed_or_owner_chk: assert property (@(posedge clk) disable iff (rst)
            (pal_mode && (term & owned_terms(o)) == '0) |-> !f[o]);

        // R7
        unlinked_output_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (!pal_mode && or_map[o] == '0) |-> !f[o]);
    end
endmodule

// File: rtl/lpa_array.sv
module lpa_array
    import lpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift,
    input  logic             cfg_din,
    input  logic             cfg_commit,
    input  logic [N_IN-1:0]  x_in,
    output logic [N_OUT-1:0] f_out
);
    cfg_t              cfg;
    logic [N_TERM-1:0] term;

    lpa_cfg_chain u_chain (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (cfg_shift),
        .ser_in     (cfg_din),
        .commit     (cfg_commit),
        .active_cfg (cfg)
    );

    lpa_and_plane u_and (
        .clk     (clk),
        .rst     (rst),
        .and_map (cfg.and_map),
        .x       (x_in),
        .term    (term)
    );

    lpa_or_plane u_or (
        .clk      (clk),
        .rst      (rst),
        .or_map   (cfg.or_map),
        .pal_mode (cfg.pal_mode),
        .term     (term),
        .f        (f_out)
    );

    // R1
    reset_output_zero_chk: assert property (@(posedge clk)
        rst |=> (f_out == '0));
endmodule

// File: tb/lpa_array_tb_top.sv
module lpa_array_tb_top;
    import lpa_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_shift = 1'b0;
    logic            cfg_din = 1'b0;
    logic            cfg_commit = 1'b0;
    logic [N_IN-1:0] x_in = '0;
    logic [N_OUT-1:0] f_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [CFG_W-1:0] m_shadow = '0;
    logic [CFG_W-1:0] m_active = '0;

    always #10 clk = ~clk;

    lpa_array dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_shift  (cfg_shift),
        .cfg_din    (cfg_din),
        .cfg_commit (cfg_commit),
        .x_in       (x_in),
        .f_out      (f_out)
    );

    // Field positions as stated in R3.
    function automatic int and_pos(int t, int i, bit inv);
        return 1 + OR_BITS + t * N_LIT + 2 * i + (inv ? 1 : 0);
    endfunction
    function automatic int or_pos(int o, int t);
        return 1 + o * N_TERM + t;
    endfunction

    // Behavioural evaluation from R5 through R8.
    function automatic logic [N_OUT-1:0] ref_eval(logic [CFG_W-1:0] c, logic [N_IN-1:0] x);
        logic [N_OUT-1:0] r = '0;
        for (int t = 0; t < N_TERM; t++) begin
            bit p = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (c[and_pos(t, i, 1'b0)] && !x[i]) p = 1'b0;
                if (c[and_pos(t, i, 1'b1)] &&  x[i]) p = 1'b0;
            end
            for (int o = 0; o < N_OUT; o++) begin
                bit linked = c[0] ? (t / (N_TERM / N_OUT) == o) : c[or_pos(o, t)];
                if (linked && p) r[o] = 1'b1;
            end
        end
        return r;
    endfunction

    // Cycle model of the chain (R2, R4, R10).
    always @(posedge clk) begin
        if (rst) begin
            m_shadow <= '0;
            m_active <= '0;
        end else begin
            if (cfg_commit) m_active <= m_shadow;
            if (cfg_shift)  m_shadow <= {m_shadow[CFG_W-2:0], cfg_din};
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (f_out !== ref_eval(m_active, x_in)) begin
                errors++;
                $display("FAIL R7 per-clock model: actual %b expected %b", f_out,
                         ref_eval(m_active, x_in));
            end
        end
    end

    task automatic chk(string tag, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic shift_in(logic [CFG_W-1:0] v, int nbits);
        for (int k = CFG_W - 1; k >= CFG_W - nbits; k--) begin
            cfg_shift = 1'b1;
            cfg_din   = v[k];
            tick();
        end
        cfg_shift = 1'b0;
        cfg_din   = 1'b0;
    endtask

    task automatic commit_now();
        cfg_commit = 1'b1;
        tick();
        cfg_commit = 1'b0;
    endtask

    task automatic sweep(string tag, logic [CFG_W-1:0] c);
        for (int x = 0; x < (1 << N_IN); x++) begin
            x_in = x[N_IN-1:0];
            #3;
            chk(tag, f_out, ref_eval(c, x_in));
            tick();
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [CFG_W-1:0] ex, c;
        logic [N_OUT-1:0] e;
        logic x1, x2, x3;

        tick();
        tick();
        rst = 1'b0;

        // R1: cleared configuration gives 0 everywhere.
        sweep("R1 reset output", '0);

        // R9 pattern: T0=x1x2, T1=x1'x2'x3, T2=x1x3', T3=x1x3.
        ex = '0;
        ex[and_pos(0, 0, 0)] = 1; ex[and_pos(0, 1, 0)] = 1;
        ex[and_pos(1, 0, 1)] = 1; ex[and_pos(1, 1, 1)] = 1; ex[and_pos(1, 2, 0)] = 1;
        ex[and_pos(2, 0, 0)] = 1; ex[and_pos(2, 2, 1)] = 1;
        ex[and_pos(3, 0, 0)] = 1; ex[and_pos(3, 2, 0)] = 1;
        ex[or_pos(0, 0)] = 1; ex[or_pos(0, 1)] = 1; ex[or_pos(0, 2)] = 1;
        ex[or_pos(1, 0)] = 1; ex[or_pos(1, 1)] = 1; ex[or_pos(1, 3)] = 1;
        shift_in(ex, CFG_W);
        commit_now();
        for (int x = 0; x < 8; x++) begin
            x_in = x[2:0];
            x1 = x_in[0]; x2 = x_in[1]; x3 = x_in[2];
            e[0] = (x1 & x2) | (x1 & ~x3) | (~x1 & ~x2 & x3);
            e[1] = (x1 & x2) | (~x1 & ~x2 & x3) | (x1 & x3);
            #3;
            chk("R9 shared-term functions (R2 R3 order)", f_out, e);
            tick();
        end

        // R4: half a new pattern shifted without commit leaves outputs alone.
        shift_in('1, CFG_W / 2);
        sweep("R4 no commit keeps pattern", ex);

        // R5 and R7: empty term 0 to output 0 only, output 1 unlinked.
        c = '0;
        c[or_pos(0, 0)] = 1;
        shift_in(c, CFG_W);
        commit_now();
        for (int x = 0; x < 8; x++) begin
            x_in = x[2:0];
            #3;
            chk("R5 empty term is one, R7 unlinked output zero", f_out, 2'b01);
            tick();
        end

        // R6: contradictory term linked to both outputs.
        c = '0;
        c[and_pos(2, 1, 0)] = 1; c[and_pos(2, 1, 1)] = 1;
        c[or_pos(0, 2)] = 1; c[or_pos(1, 2)] = 1;
        shift_in(c, CFG_W);
        commit_now();
        for (int x = 0; x < 8; x++) begin
            x_in = x[2:0];
            #3;
            chk("R6 contradiction is zero", f_out, 2'b00);
            tick();
        end

        // R7: one term x2 feeding both outputs.
        c = '0;
        c[and_pos(1, 1, 0)] = 1;
        c[or_pos(0, 1)] = 1; c[or_pos(1, 1)] = 1;
        shift_in(c, CFG_W);
        commit_now();
        for (int x = 0; x < 8; x++) begin
            x_in = x[2:0];
            #3;
            chk("R7 shared term", f_out, {x_in[1], x_in[1]});
            tick();
        end

        // R8: fixed-OR mode, T0=x1 and T3=x3', stray OR bits cross-link.
        c = '0;
        c[0] = 1;
        c[and_pos(0, 0, 0)] = 1;
        c[and_pos(1, 0, 1)] = 1; c[and_pos(1, 0, 0)] = 1;
        c[and_pos(2, 0, 1)] = 1; c[and_pos(2, 0, 0)] = 1;
        c[and_pos(3, 2, 1)] = 1;
        c[or_pos(1, 0)] = 1; c[or_pos(0, 3)] = 1;
        shift_in(c, CFG_W);
        commit_now();
        for (int x = 0; x < 8; x++) begin
            x_in = x[2:0];
            #3;
            chk("R8 fixed OR ownership", f_out, {~x_in[2], x_in[0]});
            tick();
        end

        // R10: shadow holds ex; commit during a shift takes ex.
        shift_in(ex, CFG_W);
        cfg_shift = 1'b1;
        cfg_din = 1'b1;
        cfg_commit = 1'b1;
        tick();
        cfg_shift = 1'b0;
        cfg_commit = 1'b0;
        sweep("R10 commit with shift", ex);

        // R1: reset again after a loaded pattern.
        rst = 1'b1;
        tick();
        rst = 1'b0;
        sweep("R1 reset after load", '0);

        summary();
    end
endmodule